// File: doc/BRIEF.md
# Bus Cycle Idle State Inserter

This block sequences the states of each access on an external memory bus. Every access passes through three bus states in a fixed order: T1, T2 and T3. After T3 of a read cycle, the block can add one idle state, TI. The idle state gives a slow memory time to release the data bus before the next access drives it. The address decoder that sits ahead of the block reports three things with each request: the chip-select space index, the direction, and whether the target is an on-chip area.

A 16-bit configuration word holds one idle-enable bit for each of the eight chip-select spaces. The enables sit in the odd bit positions. The even positions are always zero. After reset, idle insertion is enabled for every space. The block reports the current bus state and a busy flag. It also raises a done pulse in the last state of each access, so the requester knows the next access can start on the following clock.

A request that arrives while an access is in progress goes into a one-entry holding slot. It starts the clock after the current access ends, with no idle clock in between.

Top module: `bus_idle_inserter`

## Requirements
- R1: After reset, `busState` is 0 (idle), `busy` and `cycleDone` are low, and `cfgRdData` reads 0xAAAA.
- R2: `busState` encodes idle=0, T1=1, T2=2, T3=3, TI=4. A request taken while idle gives T1, T2 and T3 on the next three clocks. The block returns to idle after the final state if no further request is waiting.
- R3: A read to an external area (`reqInternal`=0) for space n gives one TI state right after T3 when configuration bit 2n+1 is 1.
- R4: A write cycle (`reqRead`=0) never gets a TI state, whatever the configuration holds.
- R5: An access with `reqInternal`=1 never gets a TI state, whatever the configuration holds.
- R6: A read to an external area for space n has no TI state when configuration bit 2n+1 is 0. T3 is then the final state.
- R7: A write through `cfgWrEn` loads the whole 16-bit word on the next clock. Even bit positions are dropped and always read back as 0. The word changes only on a write.
- R8: The space index, direction, on-chip flag and enable bit are taken when the access starts at T1. A configuration write during the access does not change that access's idle decision.
- R9: A request that arrives during T3 or TI of an access starts at T1 on the clock right after that access's final state.
- R10: `cycleDone` is high exactly in the final state of each access: TI when it is inserted, otherwise T3. `busy` is high in every non-idle state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | One-clock access request strobe |
| reqCs | input | 3 | Chip-select space index of the request |
| reqRead | input | 1 | 1 for a read, 0 for a write |
| reqInternal | input | 1 | 1 when the target is an on-chip area |
| cfgWrEn | input | 1 | Configuration word write strobe |
| cfgWrData | input | 16 | Configuration word write data |
| cfgRdData | output | 16 | Configuration word read-back |
| busState | output | 3 | Current bus state code |
| busy | output | 1 | An access is in progress |
| cycleDone | output | 1 | Final state of the current access |

## Verification
The assertions assume that the holding slot never overflows. A new request may arrive while a request is already held only on the clock where the held one starts. The assertions also assume that each request is a single-clock strobe. The stimulus keeps within these limits. It issues a first request only from idle. It adds at most one follow-on request, placed either in T3 or in the final state of the running access. Configuration writes happen only while idle, or in T1 of an access to exercise the launch-time sampling.

// File: rtl/bus_idle_pkg.sv
package bus_idle_pkg;

  typedef enum logic [2:0] {
    BS_IDLE = 3'd0,
    BS_T1   = 3'd1,
    BS_T2   = 3'd2,
    BS_T3   = 3'd3,
    BS_TI   = 3'd4
  } busState_e;

  typedef struct packed {
    logic launch;    // start T1 on the next clock
    logic fromPend;  // launch takes its fields from the holding slot
    logic capPend;   // store the incoming request in the holding slot
  } seqStrobe_t;

endpackage

// File: rtl/bus_idle_dp.sv
module bus_idle_dp
  import bus_idle_pkg::*;
#(
  parameter int NUM_CS = 8,
  parameter int CS_W   = $clog2(NUM_CS),
  parameter int REG_W  = 2 * NUM_CS
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strobe,
  input  logic [CS_W-1:0]  reqCs,
  input  logic             reqRead,
  input  logic             reqInternal,
  input  logic             cfgWrEn,
  input  logic [REG_W-1:0] cfgWrData,
  output logic [REG_W-1:0] cfgRdData,
  output logic             pendValid,
  output logic             curRead,
  output logic             curInternal,
  output logic             curIdle
);

  function automatic logic [REG_W-1:0] buildOddMask();
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_CS; i++) m[2*i+1] = 1'b1;
    return m;
  endfunction

  localparam logic [REG_W-1:0] ODD_MASK = buildOddMask();

  logic [REG_W-1:0]  cfgReg;
  logic [NUM_CS-1:0] enVec;
  logic [CS_W-1:0]   pendCs;
  logic              pendRead;
  logic              pendInternal;
  logic [CS_W-1:0]   srcCs;
  logic              srcRead;
  logic              srcInternal;
  logic              launchIdle;

  // Configuration word: only odd positions are stored
  always_ff @(posedge clk) begin
    if (!rstN)        cfgReg <= ODD_MASK;
    else if (cfgWrEn) cfgReg <= cfgWrData & ODD_MASK;
  end

  assign cfgRdData = cfgReg;

  for (genvar i = 0; i < NUM_CS; i++) begin : g_en
    assign enVec[i] = cfgReg[2*i+1];
  end

  // One-entry holding slot for a request that arrives mid-access
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendValid    <= 1'b0;
      pendCs       <= '0;
      pendRead     <= 1'b0;
      pendInternal <= 1'b0;
    end else if (strobe.capPend) begin
      pendValid    <= 1'b1;
      pendCs       <= reqCs;
      pendRead     <= reqRead;
      pendInternal <= reqInternal;
    end else if (strobe.launch && strobe.fromPend) begin
      pendValid    <= 1'b0;
    end
  end

  always_comb begin
    srcCs       = strobe.fromPend ? pendCs       : reqCs;
    srcRead     = strobe.fromPend ? pendRead     : reqRead;
    srcInternal = strobe.fromPend ? pendInternal : reqInternal;
    launchIdle  = srcRead && !srcInternal && enVec[srcCs];
  end

  // Per-access fields, frozen at launch
  always_ff @(posedge clk) begin
    if (!rstN) begin
      curRead     <= 1'b0;
      curInternal <= 1'b0;
      curIdle     <= 1'b0;
    end else if (strobe.launch) begin
      curRead     <= srcRead;
      curInternal <= srcInternal;
      curIdle     <= launchIdle;
    end
  end

  // R8: the idle decision of a running access holds until the next launch
  p_cur_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.launch |=> $stable({curRead, curInternal, curIdle}));

  // R7: the configuration word changes only through a write
  p_cfg_stable_r7: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWrEn |=> $stable(cfgRdData));

  // R7: even positions read back as zero after any write
  p_cfg_even_r7: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrEn |=> ((cfgRdData & ~ODD_MASK) == '0));

endmodule

// File: rtl/bus_idle_fsm.sv
module bus_idle_fsm
  import bus_idle_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       pendValid,
  input  logic       curRead,
  input  logic       curInternal,
  input  logic       curIdle,
  output seqStrobe_t strobe,
  output busState_e  state,
  output logic       busy,
  output logic       cycleDone
);

  busState_e nextState;
  logic      lastState;
  logic      launch;

  always_comb begin
    lastState = ((state == BS_T3) && !curIdle) || (state == BS_TI);
    launch    = ((state == BS_IDLE) || lastState) && (pendValid || reqValid);
    strobe.launch   = launch;
    strobe.fromPend = pendValid;
    strobe.capPend  = reqValid && !(launch && !pendValid);
  end

  always_comb begin
    nextState = state;
    case (state)
      BS_IDLE: nextState = launch ? BS_T1 : BS_IDLE;
      BS_T1:   nextState = BS_T2;
      BS_T2:   nextState = BS_T3;
      BS_T3:   nextState = curIdle ? BS_TI : (launch ? BS_T1 : BS_IDLE);
      BS_TI:   nextState = launch ? BS_T1 : BS_IDLE;
      default: nextState = BS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= BS_IDLE;
    else       state <= nextState;
  end

  assign busy      = (state != BS_IDLE);
  assign cycleDone = lastState;

  p_t1_t2_r2: assert property (@(posedge clk) disable iff (!rstN)
    state == BS_T1 |=> state == BS_T2);

  p_t2_t3_r2: assert property (@(posedge clk) disable iff (!rstN)
    state == BS_T2 |=> state == BS_T3);

  p_ti_after_t3_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == BS_T3 && curIdle) |=> state == BS_TI);

  // R4, R5: TI only ever belongs to an external read
  p_ti_ext_read_r4: assert property (@(posedge clk) disable iff (!rstN)
    state == BS_TI |-> (curRead && !curInternal));

  p_done_final_r10: assert property (@(posedge clk) disable iff (!rstN)
    cycleDone |-> (state == BS_T3 || state == BS_TI));

  p_chain_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cycleDone && (reqValid || pendValid)) |=> state == BS_T1);

  // R9 input assumption: the holding slot never overflows
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rstN)
    (pendValid && reqValid) |-> launch);

endmodule

// File: rtl/bus_idle_inserter.sv
module bus_idle_inserter
  import bus_idle_pkg::*;
#(
  parameter int NUM_CS = 8,
  parameter int CS_W   = $clog2(NUM_CS),
  parameter int REG_W  = 2 * NUM_CS
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [CS_W-1:0]  reqCs,
  input  logic             reqRead,
  input  logic             reqInternal,
  input  logic             cfgWrEn,
  input  logic [REG_W-1:0] cfgWrData,
  output logic [REG_W-1:0] cfgRdData,
  output logic [2:0]       busState,
  output logic             busy,
  output logic             cycleDone
);

  seqStrobe_t strobe;
  busState_e  state;
  logic       pendValid;
  logic       curRead;
  logic       curInternal;
  logic       curIdle;

  bus_idle_fsm u_fsm (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .pendValid   (pendValid),
    .curRead     (curRead),
    .curInternal (curInternal),
    .curIdle     (curIdle),
    .strobe      (strobe),
    .state       (state),
    .busy        (busy),
    .cycleDone   (cycleDone)
  );

  bus_idle_dp #(
    .NUM_CS (NUM_CS),
    .CS_W   (CS_W),
    .REG_W  (REG_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .reqCs       (reqCs),
    .reqRead     (reqRead),
    .reqInternal (reqInternal),
    .cfgWrEn     (cfgWrEn),
    .cfgWrData   (cfgWrData),
    .cfgRdData   (cfgRdData),
    .pendValid   (pendValid),
    .curRead     (curRead),
    .curInternal (curInternal),
    .curIdle     (curIdle)
  );

  assign busState = state;

endmodule

// File: tb/bus_idle_inserter_tb.sv
module bus_idle_inserter_tb;

  localparam logic [15:0] ODD = 16'hAAAA;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [2:0]  reqCs = '0;
  logic        reqRead = 1'b0;
  logic        reqInternal = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [15:0] cfgWrData = '0;
  logic [15:0] cfgRdData;
  logic [2:0]  busState;
  logic        busy;
  logic        cycleDone;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  int cycles = 0;
  logic [15:0] shadow = ODD;

  bus_idle_inserter u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqCs(reqCs),
    .reqRead(reqRead), .reqInternal(reqInternal), .cfgWrEn(cfgWrEn),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData), .busState(busState),
    .busy(busy), .cycleDone(cycleDone)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !finished) begin
      fails = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog: got %0d cycles expected completion", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic checkEq(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic bit expIdle(input logic [15:0] cfg, input logic [2:0] cs,
                                 input bit rd, input bit intl);
    return rd && !intl && cfg[2*cs+1];
  endfunction

  function automatic string whyTag(input logic [15:0] cfg, input logic [2:0] cs,
                                   input bit rd, input bit intl);
    if (!rd) return "R4";
    if (intl) return "R5";
    if (cfg[2*cs+1]) return "R3";
    return "R6";
  endfunction

  task automatic writeCfg(input logic [15:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1;
    cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
    shadow = d & ODD;
    checkEq("R7", cfgRdData, shadow);
  endtask

  task automatic runAccess(input logic [2:0] aCs, input bit aRd, input bit aIn,
                           input bit hasB, input logic [2:0] bCs, input bit bRd,
                           input bit bIn, input bit bAtLast, input bit midWr,
                           input logic [15:0] midData);
    logic [2:0] ex[12];
    string tg[12];
    int n = 0;
    int trig;
    int lastA;
    int bStart;
    bit aI;
    bit bI;
    bit expDone;
    aI = expIdle(shadow, aCs, aRd, aIn);
    ex[n] = 3'd1; tg[n] = "R2"; n++;
    ex[n] = 3'd2; tg[n] = "R2"; n++;
    ex[n] = 3'd3; tg[n] = "R2"; n++;
    if (aI) begin ex[n] = 3'd4; tg[n] = "R3"; n++; end
    lastA = n - 1;
    trig = bAtLast ? lastA : 2;
    if (midWr) shadow = midData & ODD;
    bStart = n;
    if (hasB) begin
      bI = expIdle(shadow, bCs, bRd, bIn);
      ex[n] = 3'd1; tg[n] = "R9"; n++;
      ex[n] = 3'd2; tg[n] = "R2"; n++;
      ex[n] = 3'd3; tg[n] = "R2"; n++;
      if (bI) begin ex[n] = 3'd4; tg[n] = "R3"; n++; end
    end
    ex[n] = 3'd0; tg[n] = "R2"; n++;
    // element right after A's T3 reflects A's idle decision
    if (!(hasB && bStart == 3)) tg[3] = midWr ? "R8" : whyTag(shadow, aCs, aRd, aIn);
    if (aI) tg[3] = midWr ? "R8" : "R3";
    if (hasB && !(bStart + 3 == n - 1)) tg[bStart + 3] = "R3";
    else if (hasB) tg[bStart + 3] = whyTag(shadow, bCs, bRd, bIn);

    @(negedge clk);
    reqValid = 1'b1; reqCs = aCs; reqRead = aRd; reqInternal = aIn;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      expDone = (ex[i] == 3'd4) || (ex[i] == 3'd3 && (i + 1 >= n || ex[i+1] != 3'd4));
      checkEq(tg[i], {13'd0, busState}, {13'd0, ex[i]});
      checkEq("R10", {15'd0, busy}, {15'd0, ex[i] != 3'd0});
      checkEq("R10", {15'd0, cycleDone}, {15'd0, expDone});
      reqValid = 1'b0;
      cfgWrEn = 1'b0;
      if (i == 0 && midWr) begin cfgWrEn = 1'b1; cfgWrData = midData; end
      if (hasB && i == trig) begin
        reqValid = 1'b1; reqCs = bCs; reqRead = bRd; reqInternal = bIn;
      end
    end
    checkEq("R7", cfgRdData, shadow);
  endtask

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'h00C0FFEE);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    checkEq("R1", {13'd0, busState}, 16'd0);
    checkEq("R1", {15'd0, busy}, 16'd0);
    checkEq("R1", {15'd0, cycleDone}, 16'd0);
    checkEq("R1", cfgRdData, 16'hAAAA);

    // directed corner cases
    runAccess(3'd3, 1, 0, 0, 3'd0, 0, 0, 0, 0, 16'h0);   // R3 read, TI
    runAccess(3'd3, 0, 0, 0, 3'd0, 0, 0, 0, 0, 16'h0);   // R4 write
    runAccess(3'd5, 1, 1, 0, 3'd0, 0, 0, 0, 0, 16'h0);   // R5 internal
    writeCfg(16'hFFFF);                                  // R7 even bits dropped
    writeCfg(16'h5555);                                  // R7 reads 0
    runAccess(3'd7, 1, 0, 0, 3'd0, 0, 0, 0, 0, 16'h0);   // R6 disabled
    writeCfg(16'h0008);                                  // only space 1 enabled
    runAccess(3'd1, 1, 0, 0, 3'd0, 0, 0, 0, 0, 16'h0);   // R3 space 1
    runAccess(3'd2, 1, 0, 0, 3'd0, 0, 0, 0, 0, 16'h0);   // R6 space 2
    writeCfg(16'hAAAA);
    runAccess(3'd2, 1, 0, 1, 3'd2, 1, 0, 0, 1, 16'h0000); // R8 then R9 with new cfg
    runAccess(3'd4, 1, 0, 1, 3'd6, 1, 0, 1, 0, 16'h0);   // R9 during TI
    runAccess(3'd4, 0, 0, 1, 3'd6, 1, 0, 0, 0, 16'h0);   // R9 during T3 (final)

    // constrained random
    for (int k = 0; k < 150; k++) begin
      if ($urandom % 4 == 0) writeCfg(16'($urandom));
      runAccess(3'($urandom), 1'($urandom), ($urandom % 4 == 0),
                ($urandom % 2 == 0), 3'($urandom), 1'($urandom),
                ($urandom % 4 == 0), 1'($urandom), ($urandom % 5 == 0),
                16'($urandom));
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule